// File: doc/BRIEF.md
# Return-Address Stack with Interrupt Context

This block keeps the return addresses of a small 4-bit controller core. Four storage slots hold program counter values and a 2-bit pointer selects the current slot. The core asks for a push when it calls a subroutine, takes an interrupt or starts a table lookup. It asks for a pop when it returns. A push advances the pointer first and then writes, so the first push after reset lands in slot 0. Nesting deeper than four levels wraps around and overwrites the oldest entry without raising any flag.

A separate one-deep context register sits beside the stack. It captures the data pointer, carry flag and skip flag only when an interrupt is entered. Calls and table lookups leave it untouched. The core reads it back on interrupt return, so a pending skip decision survives the service routine.

A wake strobe puts the pointer back to its top value. The core raises it when it returns from the low-power data-retention mode. The slot contents are kept.

Top module: `rtn_stack`

## Requirements
- R1: After reset the pointer reads 3, every slot holds 0, and the context outputs (data pointer, carry, skip) read 0.
- R2: A push (`push_i` or `irq_entry_i`) moves the pointer to (pointer+1) mod 4 and stores `pc_i` in that slot on the same edge, so the first push after reset fills slot 0.
- R3: `ret_pc_o` always shows the slot the pointer selects. A pop (`pop_i` or `irq_ret_i`) steps the pointer down by one on the next edge.
- R4: A push while the pointer is 3 wraps the pointer to 0 and replaces the old slot 0 contents, with no error indication.
- R5: `irq_entry_i` performs a push and, on the same edge, loads `dp_i`, `carry_i` and `skip_i` into the context register.
- R6: The context register keeps its value through `push_i`, `pop_i` and `irq_ret_i`.
- R7: After `irq_ret_i` the context outputs still present the values saved at interrupt entry, including the skip flag, and the pointer is back where it was before the interrupt.
- R8: If a push and a pop are requested in the same cycle, the push is performed and the pop is dropped.
- R9: `wake_i` sets the pointer to 3 on the next edge, takes priority over any push or pop in that cycle, and leaves the slot contents unchanged.
- R10: A pop while the pointer is 0 wraps the pointer to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push for a call or table lookup |
| irq_entry_i | input | 1 | Push for an interrupt entry, also saves context |
| pop_i | input | 1 | Pop for a subroutine or table return |
| irq_ret_i | input | 1 | Pop for an interrupt return |
| wake_i | input | 1 | Pointer to top on leaving data-retention mode |
| pc_i | input | PC_W | PC value to save |
| dp_i | input | DP_W | Data pointer to save |
| carry_i | input | 1 | Carry flag to save |
| skip_i | input | 1 | Skip flag to save |
| ret_pc_o | output | PC_W | Slot selected by the pointer |
| dp_o | output | DP_W | Saved data pointer |
| carry_o | output | 1 | Saved carry flag |
| skip_o | output | 1 | Saved skip flag |
| sp_o | output | PTR_W | Current pointer |

## Verification
The assertions assume the core raises at most one push source (`push_i` or `irq_entry_i`) in any cycle. The same holds for the two pop sources. The priority property relies on this, and the bench drives one strobe of each kind at most. The push-over-pop case and the wake-over-push case are driven on purpose, each in a single isolated cycle. This lets the properties for those cases see the conflict while the plain advance and retreat properties stay gated away from it.

// File: rtl/rtn_stack_pkg.sv
package rtn_stack_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_WAKE = 2'd3
  } stk_op_e;
endpackage

// File: rtl/rtn_stack_ptr.sv
module rtn_stack_ptr
  import rtn_stack_pkg::*;
#(
  parameter int PTR_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  stk_op_e          op_i,
  output logic [PTR_W-1:0] sp_o,
  output logic [PTR_W-1:0] wr_idx_o
);
  localparam logic [PTR_W-1:0] Top = {PTR_W{1'b1}};
  localparam logic [PTR_W-1:0] One = PTR_W'(1);

  logic [PTR_W-1:0] sp_q;

  assign wr_idx_o = sp_q + One;  // pre-increment target, wraps mod depth
  assign sp_o     = sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sp_q <= Top;
    else begin
      unique case (op_i)
        OP_WAKE: sp_q <= Top;
        OP_PUSH: sp_q <= wr_idx_o;
        OP_POP:  sp_q <= sp_q - One;
        default: sp_q <= sp_q;
      endcase
    end
  end
endmodule

// File: rtl/rtn_stack_file.sv
module rtn_stack_file #(
  parameter int DEPTH = 4,
  parameter int PC_W  = 13,
  parameter int PTR_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PTR_W-1:0] wr_idx_i,
  input  logic [PC_W-1:0]  wr_pc_i,
  input  logic [PTR_W-1:0] rd_idx_i,
  output logic [PC_W-1:0]  rd_pc_o
);
  logic [PC_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[g] <= '0;
      else if (we_i && (wr_idx_i == PTR_W'(g))) slot_q[g] <= wr_pc_i;
    end
  end

  assign rd_pc_o = slot_q[rd_idx_i];
endmodule

// File: rtl/rtn_stack_ctx.sv
module rtn_stack_ctx #(
  parameter int DP_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            save_i,
  input  logic [DP_W-1:0] dp_i,
  input  logic            carry_i,
  input  logic            skip_i,
  output logic [DP_W-1:0] dp_o,
  output logic            carry_o,
  output logic            skip_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dp_o    <= '0;
      carry_o <= 1'b0;
      skip_o  <= 1'b0;
    end else if (save_i) begin
      dp_o    <= dp_i;
      carry_o <= carry_i;
      skip_o  <= skip_i;
    end
  end
endmodule

// File: rtl/rtn_stack.sv
module rtn_stack
  import rtn_stack_pkg::*;
#(
  parameter int PC_W  = 13,
  parameter int DP_W  = 7,
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             irq_entry_i,
  input  logic             pop_i,
  input  logic             irq_ret_i,
  input  logic             wake_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [DP_W-1:0]  dp_i,
  input  logic             carry_i,
  input  logic             skip_i,
  output logic [PC_W-1:0]  ret_pc_o,
  output logic [DP_W-1:0]  dp_o,
  output logic             carry_o,
  output logic             skip_o,
  output logic [PTR_W-1:0] sp_o
);
  stk_op_e          op;
  logic [PTR_W-1:0] wr_idx;

  // wake > push > pop
  always_comb begin
    if (wake_i)                    op = OP_WAKE;
    else if (push_i | irq_entry_i) op = OP_PUSH;
    else if (pop_i | irq_ret_i)    op = OP_POP;
    else                           op = OP_HOLD;
  end

  rtn_stack_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .sp_o     (sp_o),
    .wr_idx_o (wr_idx)
  );

  rtn_stack_file #(.DEPTH(DEPTH), .PC_W(PC_W), .PTR_W(PTR_W)) u_file (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (op == OP_PUSH),
    .wr_idx_i (wr_idx),
    .wr_pc_i  (pc_i),
    .rd_idx_i (sp_o),
    .rd_pc_o  (ret_pc_o)
  );

  rtn_stack_ctx #(.DP_W(DP_W)) u_ctx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .save_i  (irq_entry_i && !wake_i),
    .dp_i    (dp_i),
    .carry_i (carry_i),
    .skip_i  (skip_i),
    .dp_o    (dp_o),
    .carry_o (carry_o),
    .skip_o  (skip_o)
  );
endmodule

// File: rtl/rtn_stack_chk.sv
module rtn_stack_chk #(
  parameter int PC_W  = 13,
  parameter int DP_W  = 7,
  parameter int PTR_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_i,
  input logic             irq_entry_i,
  input logic             pop_i,
  input logic             irq_ret_i,
  input logic             wake_i,
  input logic [PC_W-1:0]  pc_i,
  input logic [DP_W-1:0]  dp_i,
  input logic             carry_i,
  input logic             skip_i,
  input logic [PC_W-1:0]  ret_pc_o,
  input logic [DP_W-1:0]  dp_o,
  input logic             carry_o,
  input logic             skip_o,
  input logic [PTR_W-1:0] sp_o
);
  logic push_any, pop_any;
  assign push_any = push_i | irq_entry_i;
  assign pop_any  = pop_i | irq_ret_i;

  a_r2_push_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_any && !wake_i |=> sp_o == PTR_W'($past(sp_o) + 1'b1));
  a_r2_push_stores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_any && !wake_i |=> ret_pc_o == $past(pc_i));
  a_r3_pop_retreat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_any && !push_any && !wake_i |=> sp_o == PTR_W'($past(sp_o) - 1'b1));
  a_r4_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_any && !wake_i && (sp_o == {PTR_W{1'b1}}) |=> sp_o == '0);
  a_r5_ctx_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_entry_i && !wake_i |=> dp_o == $past(dp_i) && carry_o == $past(carry_i)
                               && skip_o == $past(skip_i));
  a_r6_ctx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_entry_i |=> $stable(dp_o) && $stable(carry_o) && $stable(skip_o));
  a_r8_push_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_any && pop_any && !wake_i |=> sp_o == PTR_W'($past(sp_o) + 1'b1));
  a_r9_wake_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> sp_o == {PTR_W{1'b1}});
  a_r9_wake_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i && sp_o == {PTR_W{1'b1}} |=> $stable(ret_pc_o));
  a_r10_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_any && !push_any && !wake_i && sp_o == '0 |=> sp_o == {PTR_W{1'b1}});
endmodule

bind rtn_stack rtn_stack_chk #(.PC_W(PC_W), .DP_W(DP_W), .PTR_W(PTR_W)) u_chk (.*);

// File: tb/rtn_stack_bench.sv
`timescale 1ns/1ps
module rtn_stack_bench;
  localparam int PC_W = 13;
  localparam int DP_W = 7;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            push_i = 0, irq_entry_i = 0, pop_i = 0, irq_ret_i = 0, wake_i = 0;
  logic [PC_W-1:0] pc_i = '0;
  logic [DP_W-1:0] dp_i = '0;
  logic            carry_i = 0, skip_i = 0;
  logic [PC_W-1:0] ret_pc_o;
  logic [DP_W-1:0] dp_o;
  logic            carry_o, skip_o;
  logic [1:0]      sp_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state from the requirements
  logic [PC_W-1:0] m_slot [4];
  logic [1:0]      m_sp;
  logic [DP_W-1:0] m_dp;
  logic            m_c, m_s;

  always #2.5 clk_i = ~clk_i;

  rtn_stack u_rtn_stack (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, 32'(sp_o), 32'(m_sp));
    chk(req, 32'(ret_pc_o), 32'(m_slot[m_sp]));
    chk(req, 32'(dp_o), 32'(m_dp));
    chk(req, 32'(carry_o), 32'(m_c));
    chk(req, 32'(skip_o), 32'(m_s));
  endtask

  // one cycle of stimulus, then update the model
  task automatic step(bit pu, bit ie, bit po, bit ir, bit wk, logic [PC_W-1:0] pc,
                      logic [DP_W-1:0] dp = '0, bit c = 0, bit s = 0);
    @(negedge clk_i);
    push_i = pu; irq_entry_i = ie; pop_i = po; irq_ret_i = ir; wake_i = wk;
    pc_i = pc; dp_i = dp; carry_i = c; skip_i = s;
    @(negedge clk_i);
    push_i = 0; irq_entry_i = 0; pop_i = 0; irq_ret_i = 0; wake_i = 0;
    if (wk) m_sp = 2'd3;
    else if (pu || ie) begin
      m_sp = m_sp + 2'd1;
      m_slot[m_sp] = pc;
      if (ie) begin m_dp = dp; m_c = c; m_s = s; end
    end else if (po || ir) m_sp = m_sp - 2'd1;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) m_slot[i] = '0;
    m_sp = 2'd3; m_dp = '0; m_c = 0; m_s = 0;
    rst_ni = 0;
    repeat (2) @(negedge clk_i);
    chk_all("R1 reset");
    rst_ni = 1;
    @(negedge clk_i);
  endtask

  task automatic t_push_pop;
    step(1, 0, 0, 0, 0, 13'h0A01);
    chk("R2 first push slot0", 32'(sp_o), 32'd0);
    chk_all("R2 push");
    step(1, 0, 0, 0, 0, 13'h0B02);
    chk_all("R2 second push");
    chk("R3 top visible", 32'(ret_pc_o), 32'h0B02);
    step(0, 0, 1, 0, 0, '0);
    chk_all("R3 pop");
    chk("R3 pop returns older", 32'(ret_pc_o), 32'h0A01);
    step(0, 0, 1, 0, 0, '0);
    chk_all("R3 pop to top");
  endtask

  task automatic t_underflow;
    step(1, 0, 0, 0, 0, 13'h0123);
    step(0, 0, 1, 0, 0, '0);
    step(0, 0, 1, 0, 0, '0);
    chk("R10 underflow wrap", 32'(sp_o), 32'd2);
    chk_all("R10 underflow");
    step(0, 0, 0, 0, 1, '0);
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, PC_W'(13'h100 + i));
    chk_all("R4 full");
    step(1, 0, 0, 0, 0, 13'h1FFF);
    chk("R4 wrap ptr", 32'(sp_o), 32'd0);
    chk("R4 overwrite", 32'(ret_pc_o), 32'h1FFF);
    step(0, 0, 1, 0, 0, '0);
    chk("R4 slot3 kept", 32'(ret_pc_o), 32'h103);
    chk_all("R4 after pop");
  endtask

  task automatic t_irq;
    logic [1:0] sp_before;
    sp_before = m_sp;
    step(0, 1, 0, 0, 0, 13'h00AA, 7'h55, 1, 1);
    chk_all("R5 irq entry");
    chk("R5 skip saved", 32'(skip_o), 32'd1);
    step(1, 0, 0, 0, 0, 13'h0CCC, 7'h12, 0, 0);
    chk_all("R6 call in isr");
    chk("R6 dp unchanged", 32'(dp_o), 32'h55);
    step(0, 0, 1, 0, 0, '0, 7'h33, 0, 0);
    chk_all("R6 return in isr");
    step(0, 0, 0, 1, 0, '0, 7'h01, 0, 0);
    chk_all("R7 irq return");
    chk("R7 ptr restored", 32'(sp_o), 32'(sp_before));
    chk("R7 skip survives", 32'(skip_o), 32'd1);
    chk("R7 carry survives", 32'(carry_o), 32'd1);
  endtask

  task automatic t_table;
    logic [1:0] sp_before;
    sp_before = m_sp;
    step(1, 0, 0, 0, 0, 13'h0777, 7'h7F, 0, 0);
    chk_all("R6 table push");
    step(0, 0, 1, 0, 0, '0);
    chk("R6 table pair ptr", 32'(sp_o), 32'(sp_before));
    chk("R6 ctx after table", 32'(dp_o), 32'h55);
  endtask

  task automatic t_priority;
    step(1, 0, 1, 0, 0, 13'h0999);
    chk("R8 push wins", 32'(ret_pc_o), 32'h0999);
    chk_all("R8 push and pop");
  endtask

  task automatic t_wake;
    step(1, 0, 0, 0, 0, 13'h0444);
    step(0, 0, 0, 0, 1, '0);
    chk("R9 wake ptr", 32'(sp_o), 32'd3);
    chk_all("R9 slots kept");
    step(1, 0, 0, 0, 1, 13'h0555);
    chk("R9 wake over push", 32'(sp_o), 32'd3);
    chk_all("R9 no write");
    step(1, 0, 0, 0, 0, 13'h0666);
    chk("R9 next push slot0", 32'(sp_o), 32'd0);
    chk_all("R9 next push");
  endtask

  initial begin
    t_reset();
    t_push_pop();
    t_underflow();
    t_wrap();
    t_irq();
    t_table();
    t_priority();
    t_wake();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule